// File: doc/BRIEF.md
# Cascadable Counter and Shift Register Stage

This block is a narrow register stage (four bits by default) that either counts modulo 2^WIDTH or shifts, under a 3-bit mode select. It can also load a parallel preset, invert its contents, clear itself or hold. In count modes the stage advances only when both active-low count enables are low. The parallel preset load is what makes a programmable-modulus counter possible.

Several stages chain into a wider counter or a longer shift register over a single wire per boundary. The active-low terminal-count output of one stage drives the chained enable input of the next stage. In count modes that wire carries a ripple enable. In shift modes the output carries the stage's top bit, and the same input supplies the next stage's incoming bit 0. A second serial input feeds the top bit when shifting down.

An active-low reset clears the register at once. Its release is synchronised to the clock, so the stage acts on the third rising edge after reset goes high.

Top module: `ccsr_stage`

## Requirements
- R1: While rst_n is low, q reads 0 without waiting for a clock edge. After rst_n rises, q keeps 0 through the first two rising edges, and the mode takes effect on the third.
- R2: With mode_sel 000, a rising edge copies preset_in into q.
- R3: With mode_sel 001 and both cnt_en_par_n and cnt_en_chain_n low, each rising edge adds one to q, and q wraps from all-ones to 0.
- R4: With mode_sel 010 and both enables low, each rising edge subtracts one from q, and q wraps from 0 to all-ones.
- R5: In modes 001 and 010, q is unchanged on an edge where either enable is high.
- R6: With mode_sel 011, q shifts toward the top bit. Bit 0 takes the value of cnt_en_chain_n.
- R7: With mode_sel 100, q shifts toward bit 0. The top bit takes the value of ser_dn_in.
- R8: With mode_sel 101, every bit of q inverts on each rising edge.
- R9: With mode_sel 110, q becomes 0 on the edge. With mode_sel 111, q is held.
- R10: tc_n is low in mode 001 only when q is all-ones and cnt_en_chain_n is low. It is low in mode 010 only when q is 0 and cnt_en_chain_n is low. Otherwise it is high in those modes.
- R11: In modes 011 and 100, tc_n equals the top bit of q.
- R12: In modes 000, 101, 110 and 111, tc_n is high.
- R13: The enables have no effect in modes 000, 011 (except as serial data), 100, 101, 110 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 3 | Operating mode select |
| cnt_en_par_n | input | 1 | Active-low local count enable |
| cnt_en_chain_n | input | 1 | Active-low chained count enable; serial input when shifting up |
| preset_in | input | WIDTH | Parallel preset value |
| ser_dn_in | input | 1 | Serial input to the top bit when shifting down |
| q | output | WIDTH | Register state |
| tc_n | output | 1 | Active-low terminal count, or the top bit in shift modes |

## Verification
The register is the only state, so a wrong next-state value appears on q at the first sample after the edge that produced it. The combinational tc_n shows a wrong terminal-count decode in the same cycle, without waiting for an edge. An enable that leaks into a non-count mode, or that fails to stall a count, shows as a one-step error in q after a single edge. The table therefore places each enable combination directly before a known value. A slip in reset release timing shows as a value loaded one edge too early or too late, and the directed reset test samples q on each of the three edges to catch it.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;
  typedef enum logic [2:0] {
    MD_LOAD  = 3'd0,
    MD_UP    = 3'd1,
    MD_DOWN  = 3'd2,
    MD_SHUP  = 3'd3,
    MD_SHDN  = 3'd4,
    MD_INV   = 3'd5,
    MD_CLR   = 3'd6,
    MD_HOLD  = 3'd7
  } mode_t;

  function automatic logic is_count(mode_t m);
    return (m == MD_UP) || (m == MD_DOWN);
  endfunction

  function automatic logic is_shift(mode_t m);
    return (m == MD_SHUP) || (m == MD_SHDN);
  endfunction
endpackage

// File: rtl/ccsr_rst_sync.sv
module ccsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ccsr_next.sv
module ccsr_next
  import ccsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_t             mode,
  input  logic              en_par_n,
  input  logic              en_chain_n,
  input  logic [WIDTH-1:0]  q,
  input  logic [WIDTH-1:0]  preset,
  input  logic              ser_dn,
  output logic [WIDTH-1:0]  q_nxt,
  output logic              upd
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic [WIDTH-1:0] sh_up;
  logic [WIDTH-1:0] sh_dn;
  logic             cnt_ok;

  // shift lanes: each bit takes its lower (up) or upper (down) neighbour
  assign sh_up[0]       = en_chain_n;
  assign sh_dn[WIDTH-1] = ser_dn;
  for (genvar b = 1; b < WIDTH; b++) begin : g_up
    assign sh_up[b] = q[b-1];
  end
  for (genvar b = 0; b < WIDTH-1; b++) begin : g_dn
    assign sh_dn[b] = q[b+1];
  end

  assign cnt_ok = !en_par_n && !en_chain_n;

  always_comb begin
    q_nxt = q;
    upd   = 1'b1;
    case (mode)
      MD_LOAD: q_nxt = preset;
      MD_UP:   begin q_nxt = q + STEP; upd = cnt_ok; end
      MD_DOWN: begin q_nxt = q - STEP; upd = cnt_ok; end
      MD_SHUP: q_nxt = sh_up;
      MD_SHDN: q_nxt = sh_dn;
      MD_INV:  q_nxt = ~q;
      MD_CLR:  q_nxt = '0;
      MD_HOLD: upd   = 1'b0;
      default: upd   = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccsr_tc.sv
module ccsr_tc
  import ccsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_t            mode,
  input  logic             en_chain_n,
  input  logic [WIDTH-1:0] q,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  always_comb begin
    tc_n = 1'b1;
    case (mode)
      MD_UP:   if (!en_chain_n && q == TOP_VAL) tc_n = 1'b0;
      MD_DOWN: if (!en_chain_n && q == BOT_VAL) tc_n = 1'b0;
      MD_SHUP,
      MD_SHDN: tc_n = q[WIDTH-1];
      default: tc_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/ccsr_stage.sv
module ccsr_stage
  import ccsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             cnt_en_par_n,
  input  logic             cnt_en_chain_n,
  input  logic [WIDTH-1:0] preset_in,
  input  logic             ser_dn_in,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  mode_t            mode;
  logic             rst_sync_n;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             upd;

  assign mode = mode_t'(mode_sel);

  ccsr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccsr_next #(.WIDTH(WIDTH)) i_next (
    .mode       (mode),
    .en_par_n   (cnt_en_par_n),
    .en_chain_n (cnt_en_chain_n),
    .q          (q_r),
    .preset     (preset_in),
    .ser_dn     (ser_dn_in),
    .q_nxt      (q_nxt),
    .upd        (upd)
  );

  ccsr_tc #(.WIDTH(WIDTH)) i_tc (
    .mode       (mode),
    .en_chain_n (cnt_en_chain_n),
    .q          (q_r),
    .tc_n       (tc_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  q_r <= '0;
    else if (upd)     q_r <= q_nxt;
  end

  assign q = q_r;

  // register behaviour per mode, checked one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_LOAD) |=> (q_r == $past(preset_in)));
  p_up_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_UP && !cnt_en_par_n && !cnt_en_chain_n) |=> (q_r == $past(q_r) + WIDTH'(1)));
  p_down_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_DOWN && !cnt_en_par_n && !cnt_en_chain_n) |=> (q_r == $past(q_r) - WIDTH'(1)));
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_count(mode) && (cnt_en_par_n || cnt_en_chain_n)) |=> $stable(q_r));
  p_shup_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_SHUP) |=> (q_r[0] == $past(cnt_en_chain_n)));
  p_shdn_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_SHDN) |=> (q_r[WIDTH-1] == $past(ser_dn_in)));
  p_inv_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_INV) |=> (q_r == ~$past(q_r)));
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_CLR) |=> (q_r == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_HOLD) |=> $stable(q_r));
  // terminal count in count-up with the stage enabled announces the wrap
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_UP && !cnt_en_par_n && !tc_n) |=> (q_r == '0));
  p_tcidle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!is_count(mode) && !is_shift(mode)) |-> tc_n);
endmodule

// File: tb/test_ccsr_stage.sv
module test_ccsr_stage;
  localparam int W  = 4;
  localparam int NV = 23;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode_sel;
  logic         pen_n;
  logic         cen_n;
  logic [W-1:0] preset;
  logic         sdn;
  logic [W-1:0] q;
  logic         tc_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ccsr_stage #(.WIDTH(W)) i_ccsr_stage (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_sel       (mode_sel),
    .cnt_en_par_n   (pen_n),
    .cnt_en_chain_n (cen_n),
    .preset_in      (preset),
    .ser_dn_in      (sdn),
    .q              (q),
    .tc_n           (tc_n)
  );

  // {mode, pen_n, cen_n, preset, ser_dn, expected q, expected tc_n}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b1, 4'hA, 1'b0, 4'hA, 1'b1}, // R2 load
    {3'd1, 1'b0, 1'b0, 4'h0, 1'b0, 4'hB, 1'b1}, // R3 up
    {3'd1, 1'b1, 1'b0, 4'h0, 1'b0, 4'hB, 1'b1}, // R5 pen high
    {3'd0, 1'b1, 1'b1, 4'hE, 1'b0, 4'hE, 1'b1}, // R2
    {3'd1, 1'b0, 1'b0, 4'h0, 1'b0, 4'hF, 1'b0}, // R3 R10 tc at top
    {3'd1, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b1}, // R3 wrap
    {3'd1, 1'b0, 1'b1, 4'h0, 1'b0, 4'h0, 1'b1}, // R5 cen high
    {3'd2, 1'b0, 1'b0, 4'h0, 1'b0, 4'hF, 1'b1}, // R4 wrap down
    {3'd0, 1'b1, 1'b1, 4'h1, 1'b0, 4'h1, 1'b1}, // R2
    {3'd2, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0}, // R4 R10 tc at 0
    {3'd2, 1'b0, 1'b1, 4'h0, 1'b0, 4'h0, 1'b1}, // R5 R10 cen high
    {3'd2, 1'b1, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0}, // R5 R10 pen high
    {3'd0, 1'b1, 1'b1, 4'h5, 1'b0, 4'h5, 1'b1}, // R2
    {3'd3, 1'b0, 1'b1, 4'h0, 1'b0, 4'hB, 1'b1}, // R6 R11 R13
    {3'd3, 1'b1, 1'b0, 4'h0, 1'b0, 4'h6, 1'b0}, // R6 R11
    {3'd4, 1'b0, 1'b0, 4'h0, 1'b1, 4'hB, 1'b1}, // R7 R11
    {3'd4, 1'b1, 1'b1, 4'h0, 1'b0, 4'h5, 1'b0}, // R7 R11
    {3'd5, 1'b0, 1'b0, 4'h0, 1'b0, 4'hA, 1'b1}, // R8 R12 R13
    {3'd5, 1'b1, 1'b1, 4'h0, 1'b0, 4'h5, 1'b1}, // R8
    {3'd6, 1'b1, 1'b1, 4'hF, 1'b0, 4'h0, 1'b1}, // R9 clear
    {3'd0, 1'b0, 1'b0, 4'h9, 1'b0, 4'h9, 1'b1}, // R13 load with enables
    {3'd7, 1'b0, 1'b0, 4'h3, 1'b1, 4'h9, 1'b1}, // R9 hold R12
    {3'd7, 1'b1, 1'b1, 4'hF, 1'b0, 4'h9, 1'b1}  // R9 hold
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 3'd7; pen_n = 1'b1; cen_n = 1'b1;
    preset = '0; sdn = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset q", int'(q), 0);
    check("R12 reset tc_n", int'(tc_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {mode_sel, pen_n, cen_n, preset, sdn} = VEC[i][14:5];
      @(negedge clk);
      check($sformatf("vec %0d q", i), int'(q), int'(VEC[i][4:1]));
      check($sformatf("vec %0d tc_n", i), int'(tc_n), int'(VEC[i][0]));
    end

    // R1: asynchronous clear, then synchronous release
    mode_sel = 3'd0; preset = 4'hF;
    @(negedge clk);
    check("R2 load before reset", int'(q), 15);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", int'(q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held edge 1", int'(q), 0);
    @(negedge clk);
    check("R1 held edge 2", int'(q), 0);
    @(negedge clk);
    check("R1 active edge 3", int'(q), 15);

    // R10: count-up tc at top only while chain enable low
    mode_sel = 3'd1; pen_n = 1'b1; cen_n = 1'b1;
    #0.5;
    check("R10 tc_n chain high", int'(tc_n), 1);
    cen_n = 1'b0;
    #0.5;
    check("R10 tc_n chain low", int'(tc_n), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule